// File: doc/BRIEF.md
# Fetch-Execute Program Sequencer

This block is the control core of a small processor. It holds the program counter and the instruction register and alternates between two phases. In the fetch phase it asks instruction memory for the word at the program counter and waits for that memory to answer. Once the word arrives, the block stores it in the instruction register and steps the counter forward by one 32-bit word, which is 4 bytes. In the execute phase, which lasts exactly one cycle, the datapath acts on the latched word. During that cycle the sequencer decides whether to redirect the counter.

Redirection is relative. The target is the counter as it stands after the step forward, plus a signed byte offset that comes from the decoder. A redirect happens unconditionally, or only when a condition holds, depending on a two-bit branch kind. The conditions come from a zero flag and a negative flag, which the datapath reports and the sequencer keeps in its own registers. The sequencer does not decode instructions and has no arithmetic beyond the counter.

Top module: `prog_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter loads `start_addr` with bits [1:0] cleared, the phase becomes fetch, the instruction register clears to 0, and both stored flags clear to 0.
- R2: In the fetch phase `imem_req` is 1 and `imem_addr` equals the counter. While `imem_valid` is 0, the counter, the instruction register and the phase stay unchanged.
- R3: At an edge in the fetch phase with `imem_valid` 1, `instr` takes `imem_rdata`, the counter becomes its old value plus 4, and the next cycle is execute.
- R4: Execute lasts one cycle and is always followed by fetch. `ph_fetch` and `ph_exec` are never both 1.
- R5: Branch kind 2'b00 means no branch. `br_taken` is 0 and the next fetch uses the incremented counter.
- R6: Branch kind 2'b01 is always taken. The next fetch address is the incremented counter plus the sign-extended `br_offset`, for example -16 for a backward jump of 16 bytes.
- R7: Branch kind 2'b10 (greater than zero) is taken only when the stored zero flag and the stored negative flag are both 0.
- R8: Branch kind 2'b11 (equal to zero) is taken only when the stored zero flag is 1.
- R9: The flags are stored from `res_zero` and `res_neg` at an edge where `flag_we` is 1. A branch decided in a cycle uses the flags stored before that cycle's edge.
- R10: Bits [1:0] of `start_addr` and of `br_offset` are ignored, so the counter always stays word aligned.
- R11: `br_kind` and `br_offset` have no effect during the fetch phase, and `br_taken` is 0 there.
- R12: Counter arithmetic wraps modulo 2^AW. Stepping from 0xFFFFFFFC gives 0, and 0 plus an offset of -8 gives 0xFFFFFFF8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_addr | input | AW | Address of the first instruction, loaded at reset |
| imem_req | output | 1 | Instruction request, high during fetch |
| imem_addr | output | AW | Byte address of the requested instruction |
| imem_valid | input | 1 | Instruction memory returns a word this cycle |
| imem_rdata | input | DW | Returned instruction word |
| br_kind | input | 2 | Decoded branch kind: 00 none, 01 always, 10 greater than zero, 11 zero |
| br_offset | input | OFFW | Signed byte offset, relative to the incremented counter |
| res_zero | input | 1 | Zero result from the datapath |
| res_neg | input | 1 | Negative result from the datapath |
| flag_we | input | 1 | Stores `res_zero` and `res_neg` |
| ph_fetch | output | 1 | Fetch phase active |
| ph_exec | output | 1 | Execute phase active |
| instr | output | DW | Instruction register |
| pc | output | AW | Program counter |
| br_taken | output | 1 | Redirect happens at the end of this execute cycle |

## Verification
A wrong counter value shows up on `imem_addr` in the first fetch cycle after the faulty update. That is one cycle after a bad increment or a bad branch resolution, so every instruction the bench retires compares the next fetch address against its own model. A corrupted phase or a wrong stored flag can stay hidden until the next conditional branch or the next memory handshake, so the stimulus sets flags right before branches that depend on them. It also changes flags in the same cycle as a branch, to expose any use of the new value instead of the stored one. A stuck instruction register is caught in the execute cycle of every instruction, because each fetched word is distinct.

// File: rtl/seq_pkg.sv
// Shared types for the program sequencer.
// Assumes one-word instructions in byte-addressed memory.
package seq_pkg;
    typedef enum logic [0:0] {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        BRK_NONE   = 2'b00,
        BRK_ALWAYS = 2'b01,
        BRK_GT     = 2'b10,
        BRK_EQ     = 2'b11
    } brk_e;

    localparam int unsigned INSTR_BYTES = 4;
    localparam int unsigned ALIGN_BITS  = 2;
endpackage

// File: rtl/seq_phase_ctrl.sv
// Phase controller: alternates fetch and execute and owns the instruction
// register. Fetch waits for the memory handshake; execute is one cycle.
// Assumes imem_rdata is valid whenever imem_valid is high.
module seq_phase_ctrl
    import seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          imem_valid,
    input  logic [DW-1:0] imem_rdata,
    output phase_e        phase,
    output logic          fetch_done,
    output logic [DW-1:0] instr
);
    phase_e phase_q;
    logic [DW-1:0] ir_q;

    // Handshake completes only while fetching
    always_comb fetch_done = (phase_q == PH_FETCH) && imem_valid;

    // Phase register: fetch -> execute on handshake, execute -> fetch always
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_FETCH;
        end else if (phase_q == PH_EXEC) begin
            phase_q <= PH_FETCH;
        end else if (imem_valid) begin
            phase_q <= PH_EXEC;
        end
    end

    // Instruction register: latched at fetch completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (fetch_done) begin
            ir_q <= imem_rdata;
        end
    end

    assign phase = phase_q;
    assign instr = ir_q;

    p_exec_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_EXEC) |=> (phase_q == PH_FETCH));
    p_fetch_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FETCH && !imem_valid) |=> (phase_q == PH_FETCH) && $stable(ir_q));
    p_ir_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_FETCH && imem_valid) |=> (ir_q == $past(imem_rdata)) && (phase_q == PH_EXEC));
endmodule

// File: rtl/seq_cond_eval.sv
// Condition evaluator: stores zero/negative flags and decides, in the
// execute phase only, whether the decoded branch kind is taken.
// Assumes flags written in a cycle affect only later branch decisions.
module seq_cond_eval
    import seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flag_we,
    input  logic       res_zero,
    input  logic       res_neg,
    input  logic [1:0] br_kind,
    input  logic       exec,
    output logic       take
);
    logic flg_z_q;
    logic flg_n_q;
    logic cond_ok;

    // Flag storage, written on request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flg_z_q <= 1'b0;
            flg_n_q <= 1'b0;
        end else if (flag_we) begin
            flg_z_q <= res_zero;
            flg_n_q <= res_neg;
        end
    end

    // Branch kind against stored flags
    always_comb begin
        case (brk_e'(br_kind))
            BRK_ALWAYS: cond_ok = 1'b1;
            BRK_GT:     cond_ok = !flg_z_q && !flg_n_q;
            BRK_EQ:     cond_ok = flg_z_q;
            default:    cond_ok = 1'b0;
        endcase
    end

    // Decision is qualified by the execute phase
    always_comb take = exec && cond_ok;

    p_fetch_no_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |-> !take);
    p_none_no_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (br_kind == 2'b00) |-> !take);
    p_gt_needs_pos_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && br_kind == 2'b10) |-> (!flg_z_q && !flg_n_q));
    p_eq_needs_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (take && br_kind == 2'b11) |-> flg_z_q);
endmodule

// File: rtl/seq_pc_unit.sv
// Program counter: loads the aligned start address at reset, steps by one
// instruction at fetch completion, and adds a sign-extended offset to the
// already stepped value when a branch is taken.
// Assumes OFFW < AW; offset and start address low bits are dropped.
module seq_pc_unit
    import seq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int OFFW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   start_addr,
    input  logic            fetch_done,
    input  logic            take,
    input  logic [OFFW-1:0] br_offset,
    output logic [AW-1:0]   pc
);
    localparam logic [AW-1:0] ALIGN_MASK = ~((AW)'((1 << ALIGN_BITS) - 1));
    localparam logic [AW-1:0] STEP       = (AW)'(INSTR_BYTES);

    logic [AW-1:0] pc_q;
    logic [AW-1:0] off_ext;

    // Sign-extend and word-align the branch offset
    always_comb off_ext = {{(AW-OFFW){br_offset[OFFW-1]}}, br_offset} & ALIGN_MASK;

    // Counter update: reset load, sequential step, relative redirect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= start_addr & ALIGN_MASK;
        end else if (fetch_done) begin
            pc_q <= pc_q + STEP;
        end else if (take) begin
            pc_q <= pc_q + off_ext;
        end
    end

    assign pc = pc_q;

    p_reset_load_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_q == ($past(start_addr) & ALIGN_MASK)));
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_done |=> (pc_q == $past(pc_q) + STEP));
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_done && !take) |=> $stable(pc_q));
    p_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[ALIGN_BITS-1:0] == '0);
endmodule

// File: rtl/prog_sequencer.sv
// Top of the fetch-execute sequencer. Connects the phase controller, the
// condition evaluator and the program counter, and exposes the memory
// request and the phase strobes to the datapath.
// Assumes the decoder drives br_kind/br_offset during the execute cycle.
module prog_sequencer
    import seq_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int OFFW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   start_addr,
    output logic            imem_req,
    output logic [AW-1:0]   imem_addr,
    input  logic            imem_valid,
    input  logic [DW-1:0]   imem_rdata,
    input  logic [1:0]      br_kind,
    input  logic [OFFW-1:0] br_offset,
    input  logic            res_zero,
    input  logic            res_neg,
    input  logic            flag_we,
    output logic            ph_fetch,
    output logic            ph_exec,
    output logic [DW-1:0]   instr,
    output logic [AW-1:0]   pc,
    output logic            br_taken
);
    phase_e        phase;
    logic          fetch_done;
    logic          take;
    logic [AW-1:0] pc_w;

    seq_phase_ctrl #(.DW(DW)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_valid (imem_valid),
        .imem_rdata (imem_rdata),
        .phase      (phase),
        .fetch_done (fetch_done),
        .instr      (instr)
    );

    seq_cond_eval u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .flag_we  (flag_we),
        .res_zero (res_zero),
        .res_neg  (res_neg),
        .br_kind  (br_kind),
        .exec     (ph_exec),
        .take     (take)
    );

    seq_pc_unit #(.AW(AW), .OFFW(OFFW)) u_pc (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_addr (start_addr),
        .fetch_done (fetch_done),
        .take       (take),
        .br_offset  (br_offset),
        .pc         (pc_w)
    );

    // Phase strobes and memory request decode
    always_comb begin
        ph_fetch = (phase == PH_FETCH);
        ph_exec  = (phase == PH_EXEC);
        imem_req = ph_fetch;
    end

    assign imem_addr = pc_w;
    assign pc        = pc_w;
    assign br_taken  = take;

    p_phase_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ph_fetch && ph_exec));
    p_req_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        imem_req |-> (imem_addr == pc) && ph_fetch);
    p_back_to_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ph_exec |=> imem_req);
endmodule

// File: tb/prog_sequencer_bench.sv
module prog_sequencer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int OFFW = 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [AW-1:0]   start_addr;
    logic            imem_req;
    logic [AW-1:0]   imem_addr;
    logic            imem_valid;
    logic [DW-1:0]   imem_rdata;
    logic [1:0]      br_kind;
    logic [OFFW-1:0] br_offset;
    logic            res_zero, res_neg, flag_we;
    logic            ph_fetch, ph_exec;
    logic [DW-1:0]   instr;
    logic [AW-1:0]   pc;
    logic            br_taken;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [DW-1:0] word;
        logic [AW-1:0] pc_exec;
        logic [AW-1:0] next_pc;
        logic          taken;
        logic [15:0]   tag;
    } exp_t;
    exp_t sb_q[$];

    logic [AW-1:0] model_pc;
    logic mz, mn;

    always #(CLK_PERIOD/2) clk = ~clk;

    prog_sequencer #(.AW(AW), .DW(DW), .OFFW(OFFW)) u_prog_sequencer (
        .clk(clk), .rst_n(rst_n), .start_addr(start_addr),
        .imem_req(imem_req), .imem_addr(imem_addr), .imem_valid(imem_valid),
        .imem_rdata(imem_rdata), .br_kind(br_kind), .br_offset(br_offset),
        .res_zero(res_zero), .res_neg(res_neg), .flag_we(flag_we),
        .ph_fetch(ph_fetch), .ph_exec(ph_exec), .instr(instr), .pc(pc),
        .br_taken(br_taken)
    );

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic model_take(input logic [1:0] k, input logic z, input logic n);
        case (k)
            2'b01:   return 1'b1;
            2'b10:   return !z && !n;
            2'b11:   return z;
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_reset(input logic [AW-1:0] sa);
        @(negedge clk);
        rst_n = 1'b0; start_addr = sa;
        imem_valid = 0; br_kind = 0; br_offset = 0; flag_we = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_pc = sa & ~32'h3; mz = 0; mn = 0;
        chk(pc == model_pc, "R1 pc", pc, model_pc);
        chk(ph_fetch && !ph_exec && imem_req, "R1 phase", {ph_fetch, ph_exec}, 2'b10);
        chk(instr == '0, "R1 instr", instr, 0);
    endtask

    task automatic set_flags(input logic z, input logic n);
        flag_we = 1; res_zero = z; res_neg = n;
        @(negedge clk);
        flag_we = 0;
        mz = z; mn = n;
    endtask

    // Driver: one instruction; expected result pushed before handshake
    task automatic do_instr(input logic [DW-1:0] word, input int lat, input logic [1:0] kind,
                            input logic [OFFW-1:0] off, input logic [15:0] tag,
                            input logic upd, input logic uz, input logic un);
        exp_t e;
        logic [AW-1:0] inc;
        logic [AW-1:0] offx;
        while (!ph_fetch) @(negedge clk);
        chk(imem_req && imem_addr == model_pc, "R2 addr", imem_addr, model_pc);
        for (int i = 0; i < lat; i++) begin
            br_kind = 2'b01; br_offset = 16'h0100;
            @(negedge clk);
            chk(pc == model_pc && ph_fetch, "R2 wait pc", pc, model_pc);
            chk(!br_taken, "R11 no take in fetch", br_taken, 0);
        end
        inc  = model_pc + 4;
        offx = {{(AW-OFFW){off[OFFW-1]}}, off} & ~32'h3;
        e.word = word; e.pc_exec = inc; e.tag = tag;
        e.taken = model_take(kind, mz, mn);
        e.next_pc = e.taken ? inc + offx : inc;
        sb_q.push_back(e);
        model_pc = e.next_pc;
        imem_valid = 1; imem_rdata = word; br_kind = kind; br_offset = off;
        @(negedge clk);
        imem_valid = 0; imem_rdata = 32'hDEAD_BEEF;
        if (upd) begin
            flag_we = 1; res_zero = uz; res_neg = un;
            mz = uz; mn = un;
        end
        @(negedge clk);
        flag_we = 0; br_kind = 0; br_offset = 0;
    endtask

    // Monitor: pops expected items at each execute cycle
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && ph_exec) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected execute", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(instr == e.word, "R3 instr", instr, e.word);
                    chk(pc == e.pc_exec, "R3 pc step", pc, e.pc_exec);
                    chk(br_taken == e.taken, {"branch decision ", string'(e.tag)}, br_taken, e.taken);
                    @(negedge clk);
                    chk(ph_fetch && !ph_exec, "R4 back to fetch", {ph_fetch, ph_exec}, 2'b10);
                    chk(imem_addr == e.next_pc, {"next fetch ", string'(e.tag)}, imem_addr, e.next_pc);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 0; start_addr = 0; imem_valid = 0; imem_rdata = 0;
        br_kind = 0; br_offset = 0; res_zero = 0; res_neg = 0; flag_we = 0;
        model_pc = 0; mz = 0; mn = 0;
        do_reset(32'h0000_1003);                                  // R1, R10
        do_instr(32'h1111_0001, 0, 2'b00, 16'h0040, "R5", 0, 0, 0);
        do_instr(32'h1111_0002, 2, 2'b00, 16'h0000, "R5", 0, 0, 0);   // R2, R11
        do_instr(32'h1111_0003, 1, 2'b01, 16'hFFF0, "R6", 0, 0, 0);   // -16
        set_flags(0, 0);
        do_instr(32'h1111_0004, 0, 2'b10, 16'h000B, "R7", 0, 0, 0);   // R10 offset
        set_flags(0, 1);
        do_instr(32'h1111_0005, 0, 2'b10, 16'h0020, "R7", 0, 0, 0);
        set_flags(1, 0);
        do_instr(32'h1111_0006, 0, 2'b10, 16'h0020, "R7", 0, 0, 0);
        do_instr(32'h1111_0007, 0, 2'b11, 16'hFFFC, "R8", 0, 0, 0);
        do_instr(32'h1111_0008, 0, 2'b11, 16'h0010, "R9", 1, 0, 0);   // old flag used
        do_instr(32'h1111_0009, 0, 2'b11, 16'h0010, "R9", 0, 0, 0);   // new flag used
        do_instr(32'h1111_000A, 3, 2'b10, 16'h0008, "R9", 0, 0, 0);
        do_reset(32'hFFFF_FFFC);
        do_instr(32'h2222_0001, 0, 2'b00, 16'h0000, "R12", 0, 0, 0);
        do_instr(32'h2222_0002, 0, 2'b01, 16'hFFF8, "R12", 0, 0, 0);
        do_instr(32'h2222_0003, 0, 2'b00, 16'h0000, "R12", 0, 0, 0);
        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R3 all retired", sb_q.size(), 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule